// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

This block watches an 8-bit temperature code delivered by an on-chip sensor, one code per valid strobe, and raises a level interrupt when the temperature crosses programmed limits. Software programs up to four upward limits and four downward limits. Each upward crossing and each downward crossing of a level sets its own sticky event bit. An enable mask chooses which event bits drive the interrupt line. Event bits stay set until software clears them by writing ones.

All programming and observation goes through a 32-bit register port. Writes take effect on the clock edge that samples the write strobe. Reads are combinational from the address. A control word starts and stops sensing. An emulation word lets software replace the sensor code with a value of its own, so thresholds and interrupt handling can be tested without heating the die.

Top module: `therm_trip_monitor`

## Requirements
- R1: After reset the control word reads 0x00600002, the run-state, current-code and event-status registers read 0, and `irq` is low.
- R2: A write to the control word (offset 0x20) whose bits [1:0] equal 3 starts sensing. Any other value in those bits stops it. Offset 0x28 reads 1 in bit 0 while sensing runs and 0 otherwise. The full control word reads back as written.
- R3: While sensing is stopped, sample strobes are ignored. The current code holds and no event bit is set.
- R4: Offset 0x40 returns the last accepted code in bits [7:0], with bits [31:8] zero.
- R5: The upward event for level i sits at bit 4i of the event status (offset 0x74). It sets when an accepted code is greater than or equal to upward limit i and the previous accepted code was below that limit. The first code accepted after reset sets no event.
- R6: The downward event for level i sits at bit 4i+16. It sets when an accepted code is less than or equal to downward limit i and the previous accepted code was above that limit.
- R7: Upward limits live at offset 0x50 and downward limits at 0x54. Level i uses bits [8i+7:8i] of each. Both registers read back as written.
- R8: The event status (0x74) and the run state (0x28) are read-only. Writes to those offsets change nothing.
- R9: Writing ones to offset 0x78 clears the event bits at those positions. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R10: The interrupt enable register (0x70) uses the same bit positions as the event status. `irq` is high exactly while some event bit and its enable bit are both set.
- R11: The emulation word (0x80) reads back as written. While its bit 0 is set, each accepted strobe takes the code in bits [15:8] in place of the sensor code, and that code is used both for the current-code register and for the comparisons.
- R12: Offset 0x00 returns the constant trim word (default 0x00000037), and writes to it are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| smp_valid | input | 1 | Sensor code valid strobe |
| smp_code | input | 8 | Sensor temperature code |
| irq | output | 1 | Level interrupt |

## Verification
The properties take for granted that the only way an event bit leaves the status is a write to the clear offset. They also assume the enable mask changes only through its own write. That lets the interrupt be checked as sticky across every other cycle. The clear property is stated only for cycles with no accepted sample, because a same-cycle event legitimately wins. The stimulus keeps clear writes apart from samples, except in the one directed case that exercises that priority. Write strobes and sample strobes are held for exactly one clock, so every accepted code is counted once.

// File: rtl/thm_pkg.sv
// Shared constants and helpers for the thermal threshold monitor.
// Assumes 8-bit codes packed four to a 32-bit threshold word.
package thm_pkg;
    localparam int CODE_W       = 8;
    localparam int REG_W        = 32;
    localparam int ADDR_W       = 8;
    localparam int MAX_LEVELS   = 4;
    localparam int LEVEL_STRIDE = 4;
    localparam int FALL_BASE    = 16;

    localparam logic [ADDR_W-1:0] OFS_TRIM = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RUN  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CUR  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RISE = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_FALL = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_IST  = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_ICLR = 8'h78;
    localparam logic [ADDR_W-1:0] OFS_EMUL = 8'h80;

    localparam logic [REG_W-1:0] CTRL_RST = 32'h0060_0002;
    localparam logic [1:0]       CMD_RUN  = 2'b11;

    typedef struct packed {
        logic [15:0]       dwell;
        logic [CODE_W-1:0] code;
        logic [6:0]        spare;
        logic              enable;
    } emul_word_t;

    // Mask of implemented event bits for n levels.
    function automatic logic [REG_W-1:0] evt_mask(input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int l = 0; l < MAX_LEVELS; l++) begin
            if (l < n) begin
                m[LEVEL_STRIDE*l]           = 1'b1;
                m[FALL_BASE+LEVEL_STRIDE*l] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/thm_level_cmp.sv
// Crossing detector for one level: flags an upward crossing of the rising
// limit and a downward crossing of the falling limit between the previous
// accepted code and the new one. Purely combinational; caller qualifies.
module thm_level_cmp
    import thm_pkg::*;
(
    input  logic [CODE_W-1:0] new_code,
    input  logic [CODE_W-1:0] old_code,
    input  logic [CODE_W-1:0] rise_lim,
    input  logic [CODE_W-1:0] fall_lim,
    output logic              rise_hit,
    output logic              fall_hit
);
    // Compare both limits against old and new codes.
    always_comb begin
        rise_hit = (new_code >= rise_lim) && (old_code < rise_lim);
        fall_hit = (new_code <= fall_lim) && (old_code > fall_lim);
    end
endmodule

// File: rtl/thm_sampler.sv
// Accepts sensor codes while sensing runs, substitutes the emulated code
// when emulation is on, and keeps the last accepted code. Assumes one
// strobe per code; strobes while stopped are dropped.
module thm_sampler
    import thm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              sense_on,
    input  logic              emul_en,
    input  logic [CODE_W-1:0] emul_code,
    output logic              accept,
    output logic [CODE_W-1:0] new_code,
    output logic [CODE_W-1:0] cur_code,
    output logic              seeded
);
    // Select the code source and qualify the strobe.
    always_comb begin
        accept   = smp_valid && sense_on;
        new_code = emul_en ? emul_code : smp_code;
    end

    // Hold the last accepted code and note that one exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_code <= '0;
            seeded   <= 1'b0;
        end else if (accept) begin
            cur_code <= new_code;
            seeded   <= 1'b1;
        end
    end
endmodule

// File: rtl/thm_evt_status.sv
// Sticky event status with write-one-to-clear and enable-masked interrupt.
// A set arriving in the same cycle as its clear wins.
module thm_evt_status
    import thm_pkg::*;
#(
    parameter int NUM_LEVELS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             seeded,
    input  logic [REG_W-1:0] hit_vec,
    input  logic [REG_W-1:0] clr_mask,
    input  logic [REG_W-1:0] irq_en,
    output logic [REG_W-1:0] evt_status,
    output logic             irq
);
    localparam logic [REG_W-1:0] LIVE = evt_mask(NUM_LEVELS);

    logic [REG_W-1:0] set_vec;

    // New events only from a qualified, non-first sample.
    always_comb begin
        set_vec = (accept && seeded) ? (hit_vec & LIVE) : '0;
    end

    // Latch events; clear requested bits unless re-set now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_status <= '0;
        end else begin
            evt_status <= (evt_status & ~clr_mask) | set_vec;
        end
    end

    // Interrupt is any enabled pending event.
    always_comb begin
        irq = |(evt_status & irq_en);
    end
endmodule

// File: rtl/thm_regs.sv
// Register file and read multiplexer. Holds control, limits, enable mask
// and emulation word; decodes the clear strobe; serves reads
// combinationally from the address.
module thm_regs
    import thm_pkg::*;
#(
    parameter int               NUM_LEVELS = 4,
    parameter logic [REG_W-1:0] TRIM_WORD  = 32'h0000_0037
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [CODE_W-1:0] cur_code,
    input  logic [REG_W-1:0]  evt_status,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              sense_on,
    output logic [REG_W-1:0]  rise_thr,
    output logic [REG_W-1:0]  fall_thr,
    output logic [REG_W-1:0]  irq_en,
    output logic              emul_en,
    output logic [CODE_W-1:0] emul_code,
    output logic [REG_W-1:0]  clr_mask
);
    localparam logic [REG_W-1:0] LIVE = evt_mask(NUM_LEVELS);

    logic [REG_W-1:0] ctrl_q;
    emul_word_t       emul_q;

    // Writable registers, updated on a write strobe to their offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RST;
            rise_thr <= '0;
            fall_thr <= '0;
            irq_en   <= '0;
            emul_q   <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_CTRL: ctrl_q   <= bus_wdata;
                OFS_RISE: rise_thr <= bus_wdata;
                OFS_FALL: fall_thr <= bus_wdata;
                OFS_IEN:  irq_en   <= bus_wdata & LIVE;
                OFS_EMUL: emul_q   <= emul_word_t'(bus_wdata);
                default:  ;
            endcase
        end
    end

    // Derived control outputs and the clear strobe.
    always_comb begin
        sense_on  = (ctrl_q[1:0] == CMD_RUN);
        emul_en   = emul_q.enable;
        emul_code = emul_q.code;
        clr_mask  = (bus_we && (bus_addr == OFS_ICLR)) ? (bus_wdata & LIVE) : '0;
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            OFS_TRIM: bus_rdata = TRIM_WORD;
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_RUN:  bus_rdata = {{(REG_W-1){1'b0}}, sense_on};
            OFS_CUR:  bus_rdata = {{(REG_W-CODE_W){1'b0}}, cur_code};
            OFS_RISE: bus_rdata = rise_thr;
            OFS_FALL: bus_rdata = fall_thr;
            OFS_IEN:  bus_rdata = irq_en;
            OFS_IST:  bus_rdata = evt_status;
            OFS_EMUL: bus_rdata = emul_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/therm_trip_monitor.sv
// Top of the thermal threshold monitor. Wires the register file, the
// sample stage, one crossing detector per level and the event status.
// Assumes NUM_LEVELS does not exceed the four lanes of a limit word.
module therm_trip_monitor
    import thm_pkg::*;
#(
    parameter int               NUM_LEVELS = 4,
    parameter logic [REG_W-1:0] TRIM_WORD  = 32'h0000_0037
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    output logic              irq
);
    logic              sense_on;
    logic              emul_en;
    logic [CODE_W-1:0] emul_code;
    logic [REG_W-1:0]  rise_thr;
    logic [REG_W-1:0]  fall_thr;
    logic [REG_W-1:0]  irq_en;
    logic [REG_W-1:0]  clr_mask;
    logic [REG_W-1:0]  evt_status;
    logic              accept;
    logic              seeded;
    logic [CODE_W-1:0] new_code;
    logic [CODE_W-1:0] cur_code;
    logic [NUM_LEVELS-1:0] rise_hits;
    logic [NUM_LEVELS-1:0] fall_hits;
    logic [REG_W-1:0]  hit_vec;

    thm_regs #(
        .NUM_LEVELS (NUM_LEVELS),
        .TRIM_WORD  (TRIM_WORD)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cur_code   (cur_code),
        .evt_status (evt_status),
        .bus_rdata  (bus_rdata),
        .sense_on   (sense_on),
        .rise_thr   (rise_thr),
        .fall_thr   (fall_thr),
        .irq_en     (irq_en),
        .emul_en    (emul_en),
        .emul_code  (emul_code),
        .clr_mask   (clr_mask)
    );

    thm_sampler u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_code  (smp_code),
        .sense_on  (sense_on),
        .emul_en   (emul_en),
        .emul_code (emul_code),
        .accept    (accept),
        .new_code  (new_code),
        .cur_code  (cur_code),
        .seeded    (seeded)
    );

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
        thm_level_cmp u_cmp (
            .new_code (new_code),
            .old_code (cur_code),
            .rise_lim (rise_thr[CODE_W*lv +: CODE_W]),
            .fall_lim (fall_thr[CODE_W*lv +: CODE_W]),
            .rise_hit (rise_hits[lv]),
            .fall_hit (fall_hits[lv])
        );
    end

    // Place each level's hits at its fixed status positions.
    always_comb begin
        hit_vec = '0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            hit_vec[LEVEL_STRIDE*l]           = rise_hits[l];
            hit_vec[FALL_BASE+LEVEL_STRIDE*l] = fall_hits[l];
        end
    end

    thm_evt_status #(
        .NUM_LEVELS (NUM_LEVELS)
    ) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .seeded     (seeded),
        .hit_vec    (hit_vec),
        .clr_mask   (clr_mask),
        .irq_en     (irq_en),
        .evt_status (evt_status),
        .irq        (irq)
    );
endmodule

// File: rtl/thm_checker.sv
// Temporal checks on the monitor, bound to the top module. Assumes the
// status leaves only via the clear offset and enables change only via
// their own write.
module thm_checker
    import thm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              sense_on,
    input logic              accept,
    input logic [CODE_W-1:0] cur_code,
    input logic [REG_W-1:0]  evt_status,
    input logic              irq
);
    a_r2_run_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL && bus_wdata[1:0] == CMD_RUN) |=> sense_on);

    a_r2_stop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL && bus_wdata[1:0] != CMD_RUN) |=> !sense_on);

    a_r3_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_on |=> $stable(cur_code));

    a_r3_no_new_events: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_on |=> ((evt_status & ~$past(evt_status)) == '0));

    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ICLR && !accept) |=> ((evt_status & $past(bus_wdata)) == '0));

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_we && (bus_addr == OFS_ICLR || bus_addr == OFS_IEN))) |=> irq);

    a_r10_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_status == '0) |-> !irq);
endmodule

bind therm_trip_monitor thm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .sense_on   (sense_on),
    .accept     (accept),
    .cur_code   (cur_code),
    .evt_status (evt_status),
    .irq        (irq)
);

// File: tb/therm_trip_monitor_bench.sv
`timescale 1ns/1ps
module therm_trip_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_code = 8'h00;
    logic        irq;

    int total = 0;
    int bad = 0;

    // Reference state
    logic        m_on = 1'b0;
    logic        m_seed = 1'b0;
    logic [7:0]  m_cur = 8'h00;
    logic [31:0] m_stat = 32'h0;
    logic [31:0] m_rise = 32'h0;
    logic [31:0] m_fall = 32'h0;
    logic [31:0] m_ien = 32'h0;
    logic [31:0] m_emul = 32'h0;
    logic [31:0] m_ctrl = 32'h0060_0002;
    localparam logic [31:0] LIVE = 32'h1111_1111;

    always #2.5 clk = ~clk;

    therm_trip_monitor u_therm_trip_monitor (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_code(smp_code), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // One clock of stimulus, then the reference update for that edge.
    task automatic step(input bit we, input logic [7:0] a, input logic [31:0] wd,
                        input bit v, input logic [7:0] code);
        logic [7:0]  eff;
        logic [31:0] ev;
        logic [31:0] clr;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; smp_valid = v; smp_code = code;
        @(negedge clk);
        bus_we = 1'b0; smp_valid = 1'b0;
        eff = m_emul[0] ? m_emul[15:8] : code;
        ev = 32'h0;
        if (v && m_on) begin
            if (m_seed) begin
                for (int l = 0; l < 4; l++) begin
                    if (eff >= m_rise[8*l +: 8] && m_cur < m_rise[8*l +: 8]) ev[4*l] = 1'b1;
                    if (eff <= m_fall[8*l +: 8] && m_cur > m_fall[8*l +: 8]) ev[16+4*l] = 1'b1;
                end
            end
            m_cur = eff;
            m_seed = 1'b1;
        end
        clr = (we && a == 8'h78) ? (wd & LIVE) : 32'h0;
        m_stat = (m_stat & ~clr) | ev;
        if (we) begin
            case (a)
                8'h20: begin m_ctrl = wd; m_on = (wd[1:0] == 2'b11); end
                8'h50: m_rise = wd;
                8'h54: m_fall = wd;
                8'h70: m_ien = wd & LIVE;
                8'h80: m_emul = wd;
                default: ;
            endcase
        end
    endtask

    task automatic check_out(input string tag);
        logic [31:0] d;
        rd(8'h40, d); chk("R4 current code", d, {24'h0, m_cur});
        rd(8'h74, d); chk(tag, d, m_stat);
        chk("R10 irq", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R12 trim and unmapped
        rd(8'h20, d); chk("R1 control reset", d, 32'h0060_0002);
        rd(8'h28, d); chk("R1 run state", d, 32'h0);
        rd(8'h40, d); chk("R1 current code", d, 32'h0);
        rd(8'h74, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd(8'h00, d); chk("R12 trim", d, 32'h0000_0037);
        rd(8'h44, d); chk("R12 unmapped", d, 32'h0);
        step(1, 8'h00, 32'hFFFF_FFFF, 0, 0);
        rd(8'h00, d); chk("R12 trim write ignored", d, 32'h0000_0037);

        // R7 limit packing readback
        step(1, 8'h50, 32'hC878_5028, 0, 0);
        step(1, 8'h54, 32'hBE6E_461E, 0, 0);
        rd(8'h50, d); chk("R7 rising limits", d, 32'hC878_5028);
        rd(8'h54, d); chk("R7 falling limits", d, 32'hBE6E_461E);

        // R3 strobes ignored while stopped
        step(0, 8'h00, 0, 1, 8'd99);
        rd(8'h40, d); chk("R3 code holds while stopped", d, 32'h0);

        // R2 start sensing
        step(1, 8'h20, 32'h0060_0003, 0, 0);
        rd(8'h28, d); chk("R2 running", d, 32'h1);
        rd(8'h20, d); chk("R2 control readback", d, 32'h0060_0003);
        step(1, 8'h70, 32'hFFFF_FFFF, 0, 0);
        rd(8'h70, d); chk("R10 enable readback", d, LIVE);

        // R5 first sample seeds only
        step(0, 8'h00, 0, 1, 8'd250);
        rd(8'h74, d); chk("R5 first sample no event", d, 32'h0);
        check_out("R5 first sample");

        // Sweep down then up in steps of 5, clearing after each sample
        for (int c = 255; c >= 0; c -= 5) begin
            step(0, 8'h00, 0, 1, 8'(c));
            check_out("R6 falling sweep");
            step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);
            rd(8'h74, d); chk("R9 clear all", d, 32'h0);
        end
        for (int c = 0; c <= 255; c += 5) begin
            step(0, 8'h00, 0, 1, 8'(c));
            check_out("R5 rising sweep");
            step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);
            rd(8'h74, d); chk("R9 clear all", d, 32'h0);
        end

        // Exact-boundary sweep for each level: hit the limit code itself
        for (int l = 0; l < 4; l++) begin
            step(0, 8'h00, 0, 1, 8'(m_rise[8*l +: 8] - 8'd1));
            step(0, 8'h00, 0, 1, m_rise[8*l +: 8]);
            check_out("R5 equal to rising limit");
            step(0, 8'h00, 0, 1, 8'(m_fall[8*l +: 8] + 8'd1));
            step(0, 8'h00, 0, 1, m_fall[8*l +: 8]);
            check_out("R6 equal to falling limit");
            step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);
        end

        // R10 enable selects which events drive irq
        step(0, 8'h00, 0, 1, 8'd100);
        step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);
        step(1, 8'h70, 32'h0000_0100, 0, 0);
        step(0, 8'h00, 0, 1, 8'd125);
        rd(8'h74, d); chk("R5 level 2 rising bit 8", d & 32'h0000_0100, 32'h0000_0100);
        chk("R10 irq with enabled event", {31'h0, irq}, 32'h1);
        step(1, 8'h70, 32'h0000_0001, 0, 0);
        chk("R10 irq masked", {31'h0, irq}, 32'h0);
        step(1, 8'h70, 32'hFFFF_FFFF, 0, 0);

        // R8 read-only registers
        held = m_cur;
        step(1, 8'h74, 32'hFFFF_FFFF, 0, 0);
        rd(8'h74, d); chk("R8 status write ignored", d, m_stat);
        step(1, 8'h28, 32'h0, 0, 0);
        rd(8'h28, d); chk("R8 run state write ignored", d, 32'h1);

        // R9 same-cycle set beats clear
        step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);
        step(0, 8'h00, 0, 1, 8'd10);
        step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);
        step(1, 8'h78, 32'hFFFF_FFFF, 1, 8'd50);
        rd(8'h74, d); chk("R9 set wins over clear", d & 32'h1, 32'h1);
        check_out("R9 priority");
        step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);

        // R11 emulation override
        step(1, 8'h80, 32'h1234_D201, 0, 0);
        rd(8'h80, d); chk("R11 emulation readback", d, 32'h1234_D201);
        step(0, 8'h00, 0, 1, 8'd10);
        rd(8'h40, d); chk("R11 emulated code used", d, 32'd210);
        check_out("R11 emulated crossing");
        step(1, 8'h80, 32'h1234_D200, 0, 0);
        step(0, 8'h00, 0, 1, 8'd20);
        rd(8'h40, d); chk("R11 sensor code after disable", d, 32'd20);
        check_out("R11 return to sensor");
        step(1, 8'h78, 32'hFFFF_FFFF, 0, 0);

        // R3 stopped: no code update, no events
        step(1, 8'h20, 32'h0060_0002, 0, 0);
        rd(8'h28, d); chk("R2 stopped", d, 32'h0);
        held = m_cur;
        step(0, 8'h00, 0, 1, 8'd255);
        rd(8'h40, d); chk("R3 code holds", d, {24'h0, held});
        rd(8'h74, d); chk("R3 no events while stopped", d, 32'h0);
        step(1, 8'h20, 32'h0060_0001, 0, 0);
        rd(8'h28, d); chk("R2 other low bits stop", d, 32'h0);
        step(1, 8'h20, 32'h0060_0003, 0, 0);
        step(0, 8'h00, 0, 1, 8'd255);
        check_out("R5 after restart");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule